// File: doc/BRIEF.md
# Supervisory Reset Pulse Generator

This block produces the system reset for a processor supervisor. It watches a digital "supply good" flag from an external threshold comparator and an active-low push-button (manual) reset input. Both are asynchronous to the block clock. Reset is asserted at once while the supply is bad or while an accepted manual request is held. Once both causes have cleared, reset stays asserted for a programmable number of clock cycles and is then released.

The hold counter starts again from zero whenever a cause reappears, so a brief supply dip during a running pulse stretches the pulse by a full hold time. A manual request is accepted only after it has stayed low for a minimum number of synchronised cycles, which rejects bounce and glitches. The reset appears in three forms:
- an active-low level;
- its active-high complement;
- a drive-low enable for an open-drain reset pad.

The comparator, the references and the pads themselves sit outside the block. Every time value is a cycle count held in a parameter.

Top module: `sup_reset_gen`

## Requirements
- R1: A supply-good flag that goes false while reset is released causes reset to assert at the third rising clock edge after the input change (two synchroniser stages plus one output register), and reset stays asserted while the flag is false.
- R2: After the supply-good flag becomes true with no manual request pending, reset is released at rising edge HOLD_CYCLES+3 after the input change: two synchroniser edges, then exactly HOLD_CYCLES cycles of hold.
- R3: If a cause (supply bad or accepted manual request) reappears while the hold is counting, the count restarts from zero. Reset is then released only HOLD_CYCLES+3 edges after the last cause clears at the input.
- R4: The manual input is accepted when the synchronised input is low for at least MIN_LOW_CYCLES consecutive cycles. A low lasting MIN_LOW_CYCLES-1 cycles leaves the reset outputs unchanged.
- R5: Once an accepted manual request has been released, reset stays asserted for the same full HOLD_CYCLES hold before release. It stays asserted for as long as the input is held low.
- R6: `reset_o` is always the exact complement of `reset_n_o`.
- R7: `reset_od_en_o` is 1 (pull the pad low) exactly when reset is asserted, and 0 (pad released) otherwise. This matches the active-low output.
- R8: An accepted manual request asserts reset at the next rising edge. From the input falling edge, this is at most MIN_LOW_CYCLES+3 edges.
- R9: While the block's own synchronous reset `rst_n` is low, all outputs show reset asserted and the hold count is cleared. After `rst_n` rises with the supply good, release follows the R2 timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Block power-on reset, synchronous, active low |
| supply_ok_i | input | 1 | Asynchronous supply-good flag from the comparator, 1 = supply above threshold |
| man_rst_n_i | input | 1 | Asynchronous manual reset request, active low |
| reset_n_o | output | 1 | System reset, active low |
| reset_o | output | 1 | System reset, active high |
| reset_od_en_o | output | 1 | Open-drain pad enable, 1 = drive pad low |

## Verification
The assertions assume that `supply_ok_i` and `man_rst_n_i` only reach the logic through the synchroniser. They also assume that the filter and hold counter see a value that is steady for a whole cycle. The stimulus meets this by changing both inputs only on the falling clock edge, so each raw level maps onto a known count of synchronised cycles. Manual pulse widths are chosen one below and exactly at the acceptance limit. Supply dips are placed in the middle of a running hold, so the restart and the boundary release edges fall on cycles the bench can name.

// File: rtl/sup_reset_pkg.sv
// Package: shared types for the supervisory reset pulse generator.
// Assumes: nothing beyond IEEE 1800-2017.
package sup_reset_pkg;

    // Phases of the reset pulse
    typedef enum logic [1:0] {
        PH_FORCE   = 2'd0,  // a cause is present, reset held
        PH_HOLD    = 2'd1,  // causes cleared, hold counter running
        PH_RELEASE = 2'd2   // reset released
    } rst_phase_t;

endpackage

// File: rtl/sup_reset_sync.sv
// Module: multi-bit, multi-stage synchroniser for independent asynchronous
// level inputs. Each bit is treated on its own (no coherence between bits).
// Assumes: STAGES >= 2; inputs are levels that stay put for several cycles.
module sup_reset_sync #(
    parameter int          WIDTH     = 2,
    parameter int          STAGES    = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    logic [WIDTH-1:0] stage_q [STAGES];

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                // Purpose: capture the raw asynchronous inputs
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[0] <= RST_VAL;
                    else        stage_q[0] <= async_i;
                end
            end else begin : g_next
                // Purpose: pass the value one stage further to settle metastability
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[s] <= RST_VAL;
                    else        stage_q[s] <= stage_q[s-1];
                end
            end
        end
    endgenerate

    assign sync_o = stage_q[STAGES-1];

endmodule

// File: rtl/sup_reset_filter.sv
// Module: minimum-width filter for the synchronised manual reset request.
// A request is accepted once it has been low for MIN_LOW_CYCLES consecutive
// cycles and stays accepted until the input returns high.
// Assumes: man_low_i is already synchronised; MIN_LOW_CYCLES >= 1.
module sup_reset_filter #(
    parameter int MIN_LOW_CYCLES = 15
) (
    input  logic clk,
    input  logic rst_n,
    input  logic man_low_i,
    output logic accept_o
);

    localparam int CW = $clog2(MIN_LOW_CYCLES + 1);
    localparam logic [CW-1:0] LIMIT = CW'(MIN_LOW_CYCLES);

    logic [CW-1:0] low_cnt_q;

    // Purpose: count consecutive low cycles, saturate at the limit, clear on high
    always_ff @(posedge clk) begin
        if (!rst_n)              low_cnt_q <= '0;
        else if (!man_low_i)     low_cnt_q <= '0;
        else if (low_cnt_q != LIMIT) low_cnt_q <= low_cnt_q + 1'b1;
    end

    assign accept_o = (low_cnt_q == LIMIT);

    // R4: acceptance can only begin after a cycle with the request low
    p_accept_after_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(accept_o) |-> $past(man_low_i));

    // R4: a high input withdraws acceptance at the next edge
    p_high_withdraws_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !man_low_i |=> !accept_o);

endmodule

// File: rtl/sup_reset_hold.sv
// Module: reset pulse state machine and hold counter. Reset is forced while
// cause_i is high, then held for HOLD_CYCLES cycles after it clears. Any
// return of the cause restarts the count. The three output forms come from
// separate registers loaded with the same next value.
// Assumes: cause_i is synchronous to clk; HOLD_CYCLES >= 1.
module sup_reset_hold
    import sup_reset_pkg::*;
#(
    parameter int HOLD_CYCLES = 20_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cause_i,
    output logic rst_n_o,
    output logic rst_o,
    output logic od_en_o
);

    localparam int CW = $clog2(HOLD_CYCLES + 1);
    localparam logic [CW-1:0] HOLD_END = CW'(HOLD_CYCLES);

    rst_phase_t    phase_q, phase_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic          rst_n_q, rst_q, od_q;
    logic          assert_d;

    // Purpose: next phase and hold count from the current cause
    always_comb begin
        phase_d = phase_q;
        cnt_d   = cnt_q;
        if (cause_i) begin
            phase_d = PH_FORCE;
            cnt_d   = '0;
        end else begin
            case (phase_q)
                PH_FORCE: begin
                    phase_d = PH_HOLD;
                    cnt_d   = CW'(1);
                end
                PH_HOLD: begin
                    if (cnt_q == HOLD_END) begin
                        phase_d = PH_RELEASE;
                        cnt_d   = '0;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
                default: begin
                    phase_d = PH_RELEASE;
                    cnt_d   = '0;
                end
            endcase
        end
    end

    assign assert_d = (phase_d != PH_RELEASE);

    // Purpose: phase and counter registers, forced phase on block reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_FORCE;
            cnt_q   <= '0;
        end else begin
            phase_q <= phase_d;
            cnt_q   <= cnt_d;
        end
    end

    // Purpose: registered output forms, all asserted on block reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rst_n_q <= 1'b0;
            rst_q   <= 1'b1;
            od_q    <= 1'b1;
        end else begin
            rst_n_q <= !assert_d;
            rst_q   <= assert_d;
            od_q    <= assert_d;
        end
    end

    assign rst_n_o = rst_n_q;
    assign rst_o   = rst_q;
    assign od_en_o = od_q;

    // R3: a cause always clears the hold count at the next edge
    p_cause_restarts_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cause_i |=> (cnt_q == '0) && !rst_n_q);

    // R2: release happens only after the full hold count
    p_release_after_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n_q) |-> ($past(cnt_q) == HOLD_END) && !$past(cause_i));

    // R6: active-high flop is the complement of the active-low flop
    p_complement_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rst_q != rst_n_q);

    // R7: open-drain enable follows the asserted state
    p_od_follows_r7: assert property (@(posedge clk) disable iff (!rst_n)
        od_q == rst_q);

endmodule

// File: rtl/sup_reset_gen.sv
// Module: supervisory reset pulse generator (top). Synchronises the supply
// flag and the manual request, filters the manual request for minimum width,
// and drives the hold state machine.
// Assumes: clock period such that MIN_LOW_CYCLES and HOLD_CYCLES express the
// wanted minimum manual width and reset pulse time; rst_n is synchronous.
module sup_reset_gen #(
    parameter int HOLD_CYCLES    = 20_000_000,
    parameter int MIN_LOW_CYCLES = 15,
    parameter int SYNC_STAGES    = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic supply_ok_i,
    input  logic man_rst_n_i,
    output logic reset_n_o,
    output logic reset_o,
    output logic reset_od_en_o
);

    localparam int SW = 2;  // bit 1: manual low request, bit 0: supply good

    logic [SW-1:0] raw_vec, sync_vec;
    logic          supply_ok_s, man_low_s, man_accept, cause;

    assign raw_vec = {!man_rst_n_i, supply_ok_i};

    sup_reset_sync #(
        .WIDTH   (SW),
        .STAGES  (SYNC_STAGES),
        .RST_VAL ('0)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (raw_vec),
        .sync_o  (sync_vec)
    );

    assign supply_ok_s = sync_vec[0];
    assign man_low_s   = sync_vec[1];

    sup_reset_filter #(
        .MIN_LOW_CYCLES (MIN_LOW_CYCLES)
    ) u_filter (
        .clk       (clk),
        .rst_n     (rst_n),
        .man_low_i (man_low_s),
        .accept_o  (man_accept)
    );

    assign cause = !supply_ok_s || man_accept;

    sup_reset_hold #(
        .HOLD_CYCLES (HOLD_CYCLES)
    ) u_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .cause_i (cause),
        .rst_n_o (reset_n_o),
        .rst_o   (reset_o),
        .od_en_o (reset_od_en_o)
    );

    // R1: a low synchronised supply flag forces reset at the next edge
    p_supply_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !supply_ok_s |=> !reset_n_o);

    // R8: an accepted manual request forces reset at the next edge
    p_manual_latency_r8: assert property (@(posedge clk) disable iff (!rst_n)
        man_accept |=> reset_o && reset_od_en_o);

endmodule

// File: tb/sup_reset_gen_test.sv
module sup_reset_gen_test;

    localparam int CLK_PERIOD = 10;
    localparam int H = 20;  // hold cycles used in the bench
    localparam int M = 4;   // minimum manual low cycles used in the bench

    typedef struct packed {
        logic       sup;
        logic       man;
        logic [7:0] ncyc;
        logic       exp_n;
        logic [3:0] req;
    } vec_t;

    localparam int NV = 19;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 1'b1, 8'd5,      1'b0, 4'd1},  // R1 supply low keeps reset
        '{1'b1, 1'b1, 8'(H+2),   1'b0, 4'd2},  // R2 last asserted edge
        '{1'b1, 1'b1, 8'd1,      1'b1, 4'd2},  // R2 release edge
        '{1'b0, 1'b1, 8'd2,      1'b1, 4'd1},  // R1 still in synchroniser
        '{1'b0, 1'b1, 8'd1,      1'b0, 4'd1},  // R1 third edge asserts
        '{1'b1, 1'b1, 8'd10,     1'b0, 4'd3},  // R3 hold half run
        '{1'b0, 1'b1, 8'd3,      1'b0, 4'd3},  // R3 dip during hold
        '{1'b1, 1'b1, 8'(H+2),   1'b0, 4'd3},  // R3 full hold restarted
        '{1'b1, 1'b1, 8'd1,      1'b1, 4'd3},  // R3 release after restart
        '{1'b1, 1'b0, 8'(M-1),   1'b1, 4'd4},  // R4 short low
        '{1'b1, 1'b1, 8'd6,      1'b1, 4'd4},  // R4 short low ignored
        '{1'b1, 1'b0, 8'(M),     1'b1, 4'd4},  // R4 minimum low
        '{1'b1, 1'b1, 8'd2,      1'b1, 4'd8},  // R8 before acceptance lands
        '{1'b1, 1'b1, 8'd1,      1'b0, 4'd8},  // R8 asserted
        '{1'b1, 1'b1, 8'(H),     1'b0, 4'd5},  // R5 hold after release
        '{1'b1, 1'b1, 8'd1,      1'b1, 4'd5},  // R5 released
        '{1'b1, 1'b0, 8'd40,     1'b0, 4'd5},  // R5 held button
        '{1'b1, 1'b1, 8'(H+3),   1'b0, 4'd5},  // R5 full hold after long press
        '{1'b1, 1'b1, 8'd1,      1'b1, 4'd5}   // R5 released
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic supply_ok_i = 1'b0;
    logic man_rst_n_i = 1'b1;
    logic reset_n_o, reset_o, reset_od_en_o;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sup_reset_gen #(
        .HOLD_CYCLES    (H),
        .MIN_LOW_CYCLES (M),
        .SYNC_STAGES    (2)
    ) uut (
        .clk           (clk),
        .rst_n         (rst_n),
        .supply_ok_i   (supply_ok_i),
        .man_rst_n_i   (man_rst_n_i),
        .reset_n_o     (reset_n_o),
        .reset_o       (reset_o),
        .reset_od_en_o (reset_od_en_o)
    );

    task automatic check(input int req, input logic exp_n);
        checks++;
        if (reset_n_o !== exp_n) begin
            fails++;
            $display("FAIL R%0d reset_n_o got %b expected %b at %0t", req, reset_n_o, exp_n, $time);
        end
        checks++;  // R6 complement
        if (reset_o !== ~exp_n) begin
            fails++;
            $display("FAIL R6 (step R%0d) reset_o got %b expected %b", req, reset_o, ~exp_n);
        end
        checks++;  // R7 open-drain enable
        if (reset_od_en_o !== ~exp_n) begin
            fails++;
            $display("FAIL R7 (step R%0d) reset_od_en_o got %b expected %b", req, reset_od_en_o, ~exp_n);
        end
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired");
            summary();
        end
    end

    initial begin
        // R9: block reset state
        repeat (3) @(posedge clk);
        #1 check(9, 1'b0);
        @(negedge clk) rst_n = 1'b1;

        // Vector walk
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            supply_ok_i = VEC[i].sup;
            man_rst_n_i = VEC[i].man;
            repeat (int'(VEC[i].ncyc)) @(posedge clk);
            #1 check(int'(VEC[i].req), VEC[i].exp_n);
        end

        // R9: block reset while released forces assertion
        @(negedge clk) rst_n = 1'b0;
        @(posedge clk);
        #1 check(9, 1'b0);
        repeat (2) @(posedge clk);
        // R9: after release with supply good, R2 timing applies
        @(negedge clk) rst_n = 1'b1;
        repeat (H + 2) @(posedge clk);
        #1 check(9, 1'b0);
        @(posedge clk);
        #1 check(9, 1'b1);

        done = 1'b1;
        summary();
    end

endmodule